// File: doc/BRIEF.md
# Optical-Black Clamp Pulse Generator

This block drives the clamp strobe that a CCD line timing generator uses to sample the optical-black reference. It runs on the pixel clock. A horizontal position counter restarts at every HD strobe, and an active-low pulse is placed between two programmable positions on each line. A vertical line counter restarts on the falling edge of VD and divides the frame into five regions. Region 0 always opens at the frame start, and regions 1 to 4 open at programmable line numbers.

Each region has its own enable bit that lets the pulse through or masks it. A force bit overrides every enable and lets the pulse through everywhere. A global control field of zero silences the pulse in every region. When the pulse leaves a masked line, it stays masked for one more line, so the first line of a region that follows a masked line carries no pulse. The horizontal position is kept in Gray code. All configuration is captured into shadow registers at the frame start, so a change never tears a frame.

Top module: `clamp_pulse_gen`

## Requirements
- R1: After reset `clamp_n` is 1 and all shadow settings are zero. Until the first VD falling edge loads the shadows, no pulse appears, whatever values sit on the configuration inputs.
- R2: The horizontal position is 0 in the cycle after a cycle with `hd` high, and it then rises by one per clock. `clamp_n` is registered and is 0 exactly in the cycle after a cycle whose position p satisfies start <= p < stop. The position is held in Gray code, and consecutive held values differ in at most one bit.
- R3: When the stop position is less than or equal to the start position, `clamp_n` stays 1 on every line.
- R4: Without `hd`, the horizontal position saturates at 2^H_W-1 and does not wrap. A long line therefore carries exactly one pulse.
- R5: When the shadowed global control field is zero, `clamp_n` stays 1 in every region. Any nonzero value lets the other settings decide.
- R6: The line counter becomes 0 on a VD falling edge and rises by one on each `hd`. The active region is the highest k in 1..4 whose start line (field k-1 of `cfg_region_start`) is at most the line count. Region 0 is active when no start line is reached.
- R7: With the force bit at 0, bit k of `cfg_region_en` set to 1 lets the pulse through in region k, and set to 0 masks it.
- R8: With the force bit at 1, the pulse appears in every region and `cfg_region_en` has no effect.
- R9: A line that follows a line masked by its region enable is also masked, even when its own region is enabled.
- R10: A VD falling edge is a cycle with `vd` low after a cycle with `vd` high. The shadows load only on that edge. A configuration change in mid-frame leaves the pulse unchanged until the next frame.
- R11: When `hd` and a VD falling edge fall in the same cycle, the line counter becomes 0 (not 1) and the horizontal position restarts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hd | input | 1 | Line start strobe, one cycle high |
| vd | input | 1 | Frame sync level; its falling edge starts a frame |
| cfg_global | input | CTRL_W | Global clamp control; zero disables the pulse |
| cfg_tog_on | input | H_W | Horizontal position where the pulse starts |
| cfg_tog_off | input | H_W | Horizontal position where the pulse ends (exclusive) |
| cfg_region_start | input | 4*V_W | Start lines of regions 1..4; field k-1 belongs to region k |
| cfg_region_en | input | 5 | Per-region enable, bit k for region k, 1 lets the pulse through |
| cfg_force_all | input | 1 | 1 lets the pulse through in all regions |
| clamp_n | output | 1 | Active-low clamp pulse, registered |

## Verification
Two things can land on the same clock edge: the line restart from a VD falling edge and the line advance from `hd`. With them come the horizontal restart and the shadow load. The bench provokes this by raising `hd` in the very cycle that `vd` drops, and it judges the result by the region pattern of the next frame. If the counter started at 1 instead of 0, every region boundary would move by one line and the per-line pulses would show it. The second collision is a region boundary that meets the one-line mask lag. A frame with a masked region between enabled ones shows whether the following region's first line stays dark.

// File: rtl/clamp_pkg.sv
`timescale 1ns/1ps
package clamp_pkg;
  localparam int NUM_REGIONS = 5;
  localparam int NUM_STARTS  = NUM_REGIONS - 1;

  typedef struct packed {
    logic                   force_all;
    logic [NUM_REGIONS-1:0] en;
  } region_cfg_t;
endpackage

// File: rtl/clamp_hcount.sv
`timescale 1ns/1ps
module clamp_hcount #(
  parameter int H_W = 12
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           hd,
  output logic [H_W-1:0] hpos
);
  logic [H_W-1:0] gray_q;
  logic [H_W-1:0] gray_d;
  logic [H_W-1:0] bin_cur;
  logic [H_W-1:0] bin_nxt;

  always_comb begin
    logic [H_W-1:0] acc;
    acc[H_W-1] = gray_q[H_W-1];
    for (int i = H_W - 2; i >= 0; i--) begin
      acc[i] = acc[i+1] ^ gray_q[i];
    end
    bin_cur = acc;
  end

  always_comb begin
    bin_nxt = bin_cur + 1'b1;
    if (hd)
      gray_d = '0;
    else if (&bin_cur)
      gray_d = gray_q;
    else
      gray_d = bin_nxt ^ (bin_nxt >> 1);
  end

  always_ff @(posedge clk) begin
    if (rst) gray_q <= '0;
    else     gray_q <= gray_d;
  end

  assign hpos = bin_cur;

  // R2: the held code changes by at most one bit between lines starts
  assert_gray_step_R2: assert property (@(posedge clk) disable iff (rst)
    !hd |=> ($countones(gray_q ^ $past(gray_q)) <= 1));
  // R4: the position holds at its top value until the next line
  assert_hpos_sat_R4: assert property (@(posedge clk) disable iff (rst)
    ((&hpos) && !hd) |=> (&hpos));
  // R2: a line strobe returns the position to zero
  assert_hd_restart_R2: assert property (@(posedge clk) disable iff (rst)
    hd |=> (hpos == '0));
endmodule

// File: rtl/clamp_vregion.sv
`timescale 1ns/1ps
module clamp_vregion
  import clamp_pkg::*;
#(
  parameter int V_W = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  hd,
  input  logic                  line_restart,
  input  logic [NUM_STARTS*V_W-1:0] starts,
  input  region_cfg_t           rcfg,
  output logic                  line_masked
);
  logic [V_W-1:0]        line_q;
  logic [V_W-1:0]        start_w [NUM_STARTS];
  logic [NUM_STARTS-1:0] hit;
  logic                  sel_en;
  logic                  mask_now;
  logic                  prev_mask_q;

  for (genvar g = 0; g < NUM_STARTS; g++) begin : g_start
    assign start_w[g] = starts[g*V_W +: V_W];
    assign hit[g]     = (line_q >= start_w[g]);
  end

  always_comb begin
    sel_en = rcfg.en[0];
    for (int k = 0; k < NUM_STARTS; k++) begin
      if (hit[k]) sel_en = rcfg.en[k+1];
    end
  end

  assign mask_now = !rcfg.force_all && !sel_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q      <= '0;
      prev_mask_q <= 1'b0;
    end else begin
      if (line_restart)
        line_q <= '0;
      else if (hd && !(&line_q))
        line_q <= line_q + 1'b1;
      if (hd || line_restart)
        prev_mask_q <= mask_now;
    end
  end

  assign line_masked = mask_now || prev_mask_q;

  // R6: a frame start returns the line count to zero
  assert_line_restart_R6: assert property (@(posedge clk) disable iff (rst)
    line_restart |=> (line_q == '0));
  // R9: a masked line keeps the following line masked
  assert_mask_lag_R9: assert property (@(posedge clk) disable iff (rst)
    ((hd || line_restart) && mask_now) |=> line_masked);
  // R8: in force mode only the lag can mask a line
  assert_force_R8: assert property (@(posedge clk) disable iff (rst)
    ((hd || line_restart) && rcfg.force_all && $past(rcfg.force_all)
     && !prev_mask_q) |=> !line_masked || !rcfg.force_all);
endmodule

// File: rtl/clamp_out.sv
`timescale 1ns/1ps
module clamp_out #(
  parameter int H_W = 12
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [H_W-1:0] hpos,
  input  logic [H_W-1:0] tog_on,
  input  logic [H_W-1:0] tog_off,
  input  logic           allow,
  output logic           clamp_n
);
  logic in_win;

  assign in_win = (hpos >= tog_on) && (hpos < tog_off);

  always_ff @(posedge clk) begin
    if (rst) clamp_n <= 1'b1;
    else     clamp_n <= !(allow && in_win);
  end

  // R3: an empty window never produces a pulse
  assert_empty_window_R3: assert property (@(posedge clk) disable iff (rst)
    (tog_off <= tog_on) |=> clamp_n);
  // R7: a blocked line keeps the output high
  assert_blocked_R7: assert property (@(posedge clk) disable iff (rst)
    !allow |=> clamp_n);
endmodule

// File: rtl/clamp_pulse_gen.sv
`timescale 1ns/1ps
module clamp_pulse_gen
  import clamp_pkg::*;
#(
  parameter int H_W    = 12,
  parameter int V_W    = 12,
  parameter int CTRL_W = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      hd,
  input  logic                      vd,
  input  logic [CTRL_W-1:0]         cfg_global,
  input  logic [H_W-1:0]            cfg_tog_on,
  input  logic [H_W-1:0]            cfg_tog_off,
  input  logic [NUM_STARTS*V_W-1:0] cfg_region_start,
  input  logic [NUM_REGIONS-1:0]    cfg_region_en,
  input  logic                      cfg_force_all,
  output logic                      clamp_n
);
  logic                      vd_q;
  logic                      vd_fall;
  logic [CTRL_W-1:0]         sh_global;
  logic [H_W-1:0]            sh_on;
  logic [H_W-1:0]            sh_off;
  logic [NUM_STARTS*V_W-1:0] sh_starts;
  region_cfg_t               sh_rcfg;
  logic [H_W-1:0]            hpos;
  logic                      line_masked;
  logic                      allow;

  assign vd_fall = vd_q && !vd;

  always_ff @(posedge clk) begin
    if (rst) begin
      vd_q      <= 1'b0;
      sh_global <= '0;
      sh_on     <= '0;
      sh_off    <= '0;
      sh_starts <= '0;
      sh_rcfg   <= '0;
    end else begin
      vd_q <= vd;
      if (vd_fall) begin
        sh_global        <= cfg_global;
        sh_on            <= cfg_tog_on;
        sh_off           <= cfg_tog_off;
        sh_starts        <= cfg_region_start;
        sh_rcfg.en        <= cfg_region_en;
        sh_rcfg.force_all <= cfg_force_all;
      end
    end
  end

  clamp_hcount #(.H_W(H_W)) u_hcount (
    .clk  (clk),
    .rst  (rst),
    .hd   (hd),
    .hpos (hpos)
  );

  clamp_vregion #(.V_W(V_W)) u_vregion (
    .clk          (clk),
    .rst          (rst),
    .hd           (hd),
    .line_restart (vd_fall),
    .starts       (sh_starts),
    .rcfg         (sh_rcfg),
    .line_masked  (line_masked)
  );

  assign allow = (sh_global != '0) && !line_masked;

  clamp_out #(.H_W(H_W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .hpos    (hpos),
    .tog_on  (sh_on),
    .tog_off (sh_off),
    .allow   (allow),
    .clamp_n (clamp_n)
  );

  // R5: a zero global field keeps the output high
  assert_global_off_R5: assert property (@(posedge clk) disable iff (rst)
    (sh_global == '0) |=> clamp_n);
  // R10: shadows hold between frame starts
  assert_shadow_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !vd_fall |=> ($stable(sh_on) && $stable(sh_off) && $stable(sh_rcfg)));
  // R1: reset leaves the output high
  assert_reset_high_R1: assert property (@(posedge clk)
    rst |=> clamp_n);
endmodule

// File: tb/clamp_pulse_gen_bench.sv
`timescale 1ns/1ps
module clamp_pulse_gen_bench;
  localparam int H_W    = 12;
  localparam int V_W    = 12;
  localparam int CTRL_W = 4;
  localparam int HMAX   = (1 << H_W) - 1;
  localparam int LMAX   = (1 << V_W) - 1;

  typedef struct {
    bit    exp;
    string tag;
  } item_t;

  logic clk = 1'b0;
  logic rst;
  logic hd;
  logic vd;
  logic [CTRL_W-1:0] cfg_global;
  logic [H_W-1:0]    cfg_tog_on;
  logic [H_W-1:0]    cfg_tog_off;
  logic [V_W-1:0]    st_b [4];
  logic [4*V_W-1:0]  cfg_region_start;
  logic [4:0]        cfg_region_en;
  logic              cfg_force_all;
  logic              clamp_n;

  assign cfg_region_start = {st_b[3], st_b[2], st_b[1], st_b[0]};

  always #2.5 clk = ~clk;

  clamp_pulse_gen #(.H_W(H_W), .V_W(V_W), .CTRL_W(CTRL_W)) u_clamp_pulse_gen (
    .clk              (clk),
    .rst              (rst),
    .hd               (hd),
    .vd               (vd),
    .cfg_global       (cfg_global),
    .cfg_tog_on       (cfg_tog_on),
    .cfg_tog_off      (cfg_tog_off),
    .cfg_region_start (cfg_region_start),
    .cfg_region_en    (cfg_region_en),
    .cfg_force_all    (cfg_force_all),
    .clamp_n          (clamp_n)
  );

  item_t sb [$];
  int    n_run  = 0;
  int    n_fail = 0;
  string cur_tag = "R1";
  bit    done = 1'b0;

  // reference model state
  int m_hpos = 0, m_line = 0, m_on = 0, m_off = 0, m_glob = 0;
  int m_start [4] = '{0, 0, 0, 0};
  bit [4:0] m_en = '0;
  bit m_force = 0, m_prev = 0, m_vdq = 0;

  task automatic step(input bit h, input bit v);
    int    rg;
    bit    mn, al, wn, vf;
    item_t it;
    @(negedge clk);
    hd = h;
    vd = v;
    rg = 0;
    for (int k = 0; k < 4; k++) if (m_line >= m_start[k]) rg = k + 1;
    mn = !m_force && !m_en[rg];
    al = (m_glob != 0) && !mn && !m_prev;
    wn = (m_hpos >= m_on) && (m_hpos < m_off);
    it.exp = !(al && wn);
    it.tag = cur_tag;
    sb.push_back(it);
    vf = m_vdq && !v;
    if (h || vf) m_prev = mn;
    if (vf) m_line = 0;
    else if (h && m_line < LMAX) m_line++;
    if (h) m_hpos = 0;
    else if (m_hpos < HMAX) m_hpos++;
    if (vf) begin
      m_glob  = int'(cfg_global);
      m_on    = int'(cfg_tog_on);
      m_off   = int'(cfg_tog_off);
      m_en    = cfg_region_en;
      m_force = cfg_force_all;
      for (int k = 0; k < 4; k++) m_start[k] = int'(st_b[k]);
    end
    m_vdq = v;
  endtask

  task automatic run_line(input int len);
    step(1'b1, 1'b0);
    for (int i = 1; i < len; i++) step(1'b0, 1'b0);
  endtask

  task automatic frame(input int nlines, input int len);
    step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    for (int l = 0; l < nlines; l++) run_line(len);
  endtask

  task automatic frame_joint(input int nlines, input int len);
    step(1'b0, 1'b1);
    for (int l = 0; l < nlines; l++) run_line(len);
  endtask

  // monitor: pops the expectation for each edge
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        it = sb.pop_front();
        n_run++;
        if (clamp_n !== it.exp) begin
          n_fail++;
          $display("FAIL %s clamp_n actual=%b expected=%b at %0t",
                   it.tag, clamp_n, it.exp, $time);
        end
      end
    end
  end

  initial begin
    #(150000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; hd = 1'b0; vd = 1'b0;
    cfg_global = 4'd1; cfg_tog_on = 12'd5; cfg_tog_off = 12'd15;
    st_b[0] = 12'd3; st_b[1] = 12'd5; st_b[2] = 12'd7; st_b[3] = 12'd9;
    cfg_region_en = 5'b11111; cfg_force_all = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    n_run++;
    if (clamp_n !== 1'b1) begin
      n_fail++;
      $display("FAIL R1 reset clamp_n actual=%b expected=1", clamp_n);
    end

    // R1: live config without a frame start gives no pulse
    cur_tag = "R1";
    for (int l = 0; l < 3; l++) run_line(30);
    // R2: all regions enabled, pulse every line
    cur_tag = "R2";
    frame(12, 30);
    // R7: regions 1 and 3 masked
    cur_tag = "R7";
    cfg_region_en = 5'b10101;
    frame(12, 30);
    // R9: region 2 masked, region 3 first line stays dark
    cur_tag = "R9";
    cfg_region_en = 5'b11011;
    frame(12, 30);
    // R6: uneven region starts
    cur_tag = "R6";
    st_b[0] = 12'd2; st_b[1] = 12'd3; st_b[2] = 12'd8; st_b[3] = 12'd10;
    cfg_region_en = 5'b10110;
    frame(13, 24);
    // R8: force mode ignores the enables
    cur_tag = "R8";
    cfg_force_all = 1'b1;
    cfg_region_en = 5'b00000;
    frame(12, 24);
    frame(12, 24);
    // R10: mid-frame change is deferred
    cur_tag = "R10";
    frame(2, 30);
    cfg_tog_on = 12'd2; cfg_tog_off = 12'd25; cfg_force_all = 1'b0;
    cfg_region_en = 5'b01111;
    for (int l = 0; l < 6; l++) run_line(30);
    frame(12, 30);
    // R3: empty and inverted windows
    cur_tag = "R3";
    cfg_region_en = 5'b11111;
    cfg_tog_on = 12'd10; cfg_tog_off = 12'd10;
    frame(6, 30);
    cfg_tog_on = 12'd20; cfg_tog_off = 12'd4;
    frame(6, 30);
    // R5: zero global field, then another nonzero value
    cur_tag = "R5";
    cfg_tog_on = 12'd3; cfg_tog_off = 12'd12;
    cfg_global = 4'd0;
    frame(6, 30);
    cfg_global = 4'd2;
    frame(6, 30);
    // R11: hd and vd falling edge together
    cur_tag = "R11";
    st_b[0] = 12'd1; st_b[1] = 12'd2; st_b[2] = 12'd4; st_b[3] = 12'd6;
    cfg_region_en = 5'b10101;
    frame_joint(9, 26);
    frame_joint(9, 26);
    // R4: saturation on a long line
    cur_tag = "R4";
    cfg_force_all = 1'b1;
    cfg_tog_on = 12'd4000; cfg_tog_off = 12'd4095;
    frame(1, 8400);
    run_line(40);

    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule